// File: doc/BRIEF.md
# Posted Write Buffer with Read Forwarding

This block sits between a command stream and a synchronous memory array. Every write is parked in a single holding register instead of going to the array at once. The parked write goes into the array only when the next write arrives, and that new write takes its place. Reads that come in between go to the array in the cycle they arrive. Reads never disturb the parked entry, so any number of them may run between two writes.

A read whose address matches the parked entry is served by forwarding. The array is still read. One cycle later, each byte lane that the parked write enables comes from the holding register, and every other lane comes from the array result. A read therefore always returns the most recent data written to that address, whether or not that data has reached the array yet.

The array is outside the block. It is assumed to accept a write in the cycle the write port is enabled. It returns read data one cycle after the read port is enabled. The command interface carries one command per cycle. When a write and a read are requested together, the write wins.

Top module: `postedWrBuf`

## Requirements
- R1: After reset the holding register is empty. No read forwards, and the first write after reset commits nothing.
- R2: Every write request is parked. A write arriving while the buffer is empty leaves the array write enable low in that cycle.
- R3: A write arriving while an entry is held drives the held address, data and byte mask onto the array write port in that same cycle, with the enable high. The new write becomes the held entry.
- R4: Cycles without a write request never enable the array write port. The held entry is unchanged by any number of reads.
- R5: A read request, with no write request in the same cycle, enables the array read port with the read address in the same cycle. The result appears on the read data output one cycle later, with the read valid output high.
- R6: A read hits when an entry is held and its address equals the read address exactly. Data is 36 bits in 4 lanes of 9 bits, and mask bit i covers data bits 9i+8 down to 9i. On a hit, lanes whose mask bit is set come from the held data and the other lanes from the array result.
- R7: A read that misses returns the array result unchanged.
- R8: When write and read requests are both asserted, the read is ignored. The array read port stays disabled and read valid stays low in the next cycle.
- R9: Over any mix of writes and reads, every read returns the newest data written to its address, with byte masks applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| wrReq | input | 1 | Write request |
| wrAddr | input | ADDR_W | Write address |
| wrData | input | 36 | Write data |
| wrMask | input | 4 | Byte lane enables of the write |
| rdReq | input | 1 | Read request |
| rdAddr | input | ADDR_W | Read address |
| arrWrEn | output | 1 | Array write enable |
| arrWrAddr | output | ADDR_W | Array write address |
| arrWrData | output | 36 | Array write data |
| arrWrMask | output | 4 | Array write lane enables |
| arrRdEn | output | 1 | Array read enable |
| arrRdAddr | output | ADDR_W | Array read address |
| arrRdData | input | 36 | Array read result, one cycle after arrRdEn |
| rdValid | output | 1 | Read result valid |
| rdData | output | 36 | Read result after forwarding |

## Verification
The bench aims at several corner cases:

- **First write after reset.** A design that commits on it would write stale zeros into the array.
- **Partial-mask hit.** A design that forwards whole words would overwrite array bytes that the parked write never enabled.
- **Repeated reads between two writes.** A design that drains the entry on a read would lose it.
- **Read colliding with a write.** A design that honours that read would issue an extra array read and raise read valid.

Random streams over a narrow address range drive frequent hits and overwrites of the parked address. A design that committed the new write instead of the old one would return stale bytes, and a comparison against a reference memory that updates immediately exposes this.

// File: rtl/pwbPkg.sv
package pwbPkg;
  // Strobes issued by the control each cycle.
  typedef struct packed {
    logic park;      // load the incoming write into the holding register
    logic commit;    // drive the held entry to the array
    logic issueRd;   // launch an array read and capture forwarding info
  } pwbStrobe_t;
endpackage

// File: rtl/pwbCtrl.sv
module pwbCtrl
  import pwbPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrReq,
  input  logic       rdReq,
  output pwbStrobe_t strobe,
  output logic       entryValid,
  output logic       rdValid
);
  logic validQ;
  logic rdValidQ;

  // A write always parks; it commits the previous entry if there is one.
  always_comb begin
    strobe.park    = wrReq;
    strobe.commit  = wrReq & validQ;
    strobe.issueRd = rdReq & ~wrReq;   // one command per cycle, write wins
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      validQ   <= 1'b0;
      rdValidQ <= 1'b0;
    end else begin
      if (strobe.park) validQ <= 1'b1;
      rdValidQ <= strobe.issueRd;
    end
  end

  assign entryValid = validQ;
  assign rdValid    = rdValidQ;
endmodule

// File: rtl/pwbDatapath.sv
module pwbDatapath
  import pwbPkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 9,
  localparam int DATA_W = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  pwbStrobe_t        strobe,
  input  logic              entryValid,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [LANES-1:0]  wrMask,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic [DATA_W-1:0] arrRdData,
  output logic [ADDR_W-1:0] heldAddr,
  output logic [DATA_W-1:0] heldData,
  output logic [LANES-1:0]  heldMask,
  output logic [DATA_W-1:0] rdData
);
  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] dataQ;
  logic [LANES-1:0]  maskQ;
  logic [LANES-1:0]  fwdSelQ;
  logic [DATA_W-1:0] fwdDataQ;
  logic              hitNow;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ <= '0;
      dataQ <= '0;
      maskQ <= '0;
    end else if (strobe.park) begin
      addrQ <= wrAddr;
      dataQ <= wrData;
      maskQ <= wrMask;
    end
  end

  assign hitNow = entryValid && (addrQ == rdAddr);

  // Forwarding info travels alongside the array read latency.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      fwdSelQ  <= '0;
      fwdDataQ <= '0;
    end else if (strobe.issueRd) begin
      fwdSelQ  <= hitNow ? maskQ : '0;
      fwdDataQ <= dataQ;
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : gLane
    assign rdData[g*LANE_W +: LANE_W] = fwdSelQ[g] ? fwdDataQ[g*LANE_W +: LANE_W]
                                                   : arrRdData[g*LANE_W +: LANE_W];
  end

  assign heldAddr = addrQ;
  assign heldData = dataQ;
  assign heldMask = maskQ;
endmodule

// File: rtl/postedWrBuf.sv
module postedWrBuf
  import pwbPkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 9,
  localparam int DATA_W = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrReq,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [LANES-1:0]  wrMask,
  input  logic              rdReq,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic              arrWrEn,
  output logic [ADDR_W-1:0] arrWrAddr,
  output logic [DATA_W-1:0] arrWrData,
  output logic [LANES-1:0]  arrWrMask,
  output logic              arrRdEn,
  output logic [ADDR_W-1:0] arrRdAddr,
  input  logic [DATA_W-1:0] arrRdData,
  output logic              rdValid,
  output logic [DATA_W-1:0] rdData
);
  pwbStrobe_t strobe;
  logic       entryValid;

  pwbCtrl u_ctrl (
    .clk(clk), .rstN(rstN), .wrReq(wrReq), .rdReq(rdReq),
    .strobe(strobe), .entryValid(entryValid), .rdValid(rdValid)
  );

  pwbDatapath #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .entryValid(entryValid),
    .wrAddr(wrAddr), .wrData(wrData), .wrMask(wrMask), .rdAddr(rdAddr),
    .arrRdData(arrRdData), .heldAddr(arrWrAddr), .heldData(arrWrData),
    .heldMask(arrWrMask), .rdData(rdData)
  );

  assign arrWrEn   = strobe.commit;
  assign arrRdEn   = strobe.issueRd;
  assign arrRdAddr = rdAddr;
endmodule

// File: rtl/pwbChecker.sv
module pwbChecker #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 9,
  localparam int DATA_W = LANES * LANE_W
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrReq,
  input logic [ADDR_W-1:0] wrAddr,
  input logic [DATA_W-1:0] wrData,
  input logic [LANES-1:0]  wrMask,
  input logic              rdReq,
  input logic [ADDR_W-1:0] rdAddr,
  input logic              arrWrEn,
  input logic [ADDR_W-1:0] arrWrAddr,
  input logic [DATA_W-1:0] arrWrData,
  input logic [LANES-1:0]  arrWrMask,
  input logic              arrRdEn,
  input logic [ADDR_W-1:0] arrRdAddr,
  input logic [DATA_W-1:0] arrRdData,
  input logic              rdValid,
  input logic [DATA_W-1:0] rdData
);
  // Shadow of the last write seen at the ports.
  logic              sValid;
  logic [ADDR_W-1:0] sAddr;
  logic [DATA_W-1:0] sData;
  logic [LANES-1:0]  sMask;
  logic [LANES-1:0]  eSel;
  logic [DATA_W-1:0] eData;
  logic [DATA_W-1:0] expMerged;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sValid <= 1'b0; sAddr <= '0; sData <= '0; sMask <= '0;
      eSel <= '0; eData <= '0;
    end else begin
      if (wrReq) begin
        sValid <= 1'b1; sAddr <= wrAddr; sData <= wrData; sMask <= wrMask;
      end
      if (rdReq && !wrReq) begin
        eSel  <= (sValid && sAddr == rdAddr) ? sMask : '0;
        eData <= sData;
      end
    end
  end

  always_comb begin
    expMerged = arrRdData;
    for (int i = 0; i < LANES; i++)
      if (eSel[i]) expMerged[i*LANE_W +: LANE_W] = eData[i*LANE_W +: LANE_W];
  end

  assert_no_commit_without_entry_R2: assert property (@(posedge clk) disable iff (!rstN)
    (wrReq && !sValid) |-> !arrWrEn);
  assert_commit_match_R3: assert property (@(posedge clk) disable iff (!rstN)
    (wrReq && sValid) |-> (arrWrEn && arrWrAddr == sAddr && arrWrData == sData && arrWrMask == sMask));
  assert_no_commit_on_idle_R4: assert property (@(posedge clk) disable iff (!rstN)
    !wrReq |-> !arrWrEn);
  assert_read_issue_R5: assert property (@(posedge clk) disable iff (!rstN)
    (rdReq && !wrReq) |-> (arrRdEn && arrRdAddr == rdAddr));
  assert_read_valid_R5: assert property (@(posedge clk) disable iff (!rstN)
    (rdReq && !wrReq) |=> rdValid);
  assert_fwd_merge_R6: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |-> (rdData == expMerged));
  assert_ignored_read_R8: assert property (@(posedge clk) disable iff (!rstN)
    (rdReq && wrReq) |-> !arrRdEn);
  assert_ignored_read_valid_R8: assert property (@(posedge clk) disable iff (!rstN)
    !(rdReq && !wrReq) |=> !rdValid);
endmodule

bind postedWrBuf pwbChecker #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_chk (
  .clk(clk), .rstN(rstN), .wrReq(wrReq), .wrAddr(wrAddr), .wrData(wrData),
  .wrMask(wrMask), .rdReq(rdReq), .rdAddr(rdAddr), .arrWrEn(arrWrEn),
  .arrWrAddr(arrWrAddr), .arrWrData(arrWrData), .arrWrMask(arrWrMask),
  .arrRdEn(arrRdEn), .arrRdAddr(arrRdAddr), .arrRdData(arrRdData),
  .rdValid(rdValid), .rdData(rdData)
);

// File: tb/postedWrBuf_bench.sv
module postedWrBuf_bench;
  localparam int ADDR_W = 6;
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int DW     = 36;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrReq = 1'b0, rdReq = 1'b0;
  logic [ADDR_W-1:0] wrAddr = '0, rdAddr = '0;
  logic [DW-1:0] wrData = '0;
  logic [3:0] wrMask = '0;
  logic arrWrEn, arrRdEn, rdValid;
  logic [ADDR_W-1:0] arrWrAddr, arrRdAddr;
  logic [DW-1:0] arrWrData, arrRdData, rdData;
  logic [3:0] arrWrMask;

  always #2.5 clk = ~clk;

  postedWrBuf u_postedWrBuf (
    .clk(clk), .rstN(rstN), .wrReq(wrReq), .wrAddr(wrAddr), .wrData(wrData),
    .wrMask(wrMask), .rdReq(rdReq), .rdAddr(rdAddr), .arrWrEn(arrWrEn),
    .arrWrAddr(arrWrAddr), .arrWrData(arrWrData), .arrWrMask(arrWrMask),
    .arrRdEn(arrRdEn), .arrRdAddr(arrRdAddr), .arrRdData(arrRdData),
    .rdValid(rdValid), .rdData(rdData)
  );

  // Array model: lane-masked write, one-cycle read.
  logic [DW-1:0] arrMem [DEPTH];
  logic [DW-1:0] refMem [DEPTH];
  logic [DW-1:0] arrRdQ;
  assign arrRdData = arrRdQ;

  function automatic logic [DW-1:0] laneMerge(logic [DW-1:0] oldW, logic [DW-1:0] newW, logic [3:0] m);
    logic [DW-1:0] r = oldW;
    for (int i = 0; i < 4; i++) if (m[i]) r[i*9 +: 9] = newW[i*9 +: 9];
    return r;
  endfunction

  always @(posedge clk) begin
    if (arrWrEn) arrMem[arrWrAddr] <= laneMerge(arrMem[arrWrAddr], arrWrData, arrWrMask);
    if (arrRdEn) arrRdQ <= arrMem[arrRdAddr];
  end

  int checks = 0, fails = 0;
  bit done = 0;
  // bench view of the parked write
  bit bValid = 0;
  logic [ADDR_W-1:0] bAddr;
  logic [DW-1:0] bData;
  logic [3:0] bMask;
  bit expRd = 0;
  logic [DW-1:0] expData;

  task automatic check(input bit ok, input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // Called at a falling edge: apply one command, check combinational outputs,
  // then at the next falling edge check the read result.
  task automatic step(input bit w, input bit r, input logic [ADDR_W-1:0] wa,
                      input logic [DW-1:0] wd, input logic [3:0] wm,
                      input logic [ADDR_W-1:0] ra, input string rdTag);
    wrReq = w; rdReq = r; wrAddr = wa; wrData = wd; wrMask = wm; rdAddr = ra;
    #1;
    check(arrWrEn == (w && bValid), (w && bValid) ? "R3" : (w ? "R2" : "R4"),
          {35'd0, arrWrEn}, {35'd0, w && bValid});
    if (w && bValid) begin
      check(arrWrAddr == bAddr && arrWrMask == bMask, "R3", {26'd0, arrWrMask, arrWrAddr}, {26'd0, bMask, bAddr});
      check(arrWrData == bData, "R3", arrWrData, bData);
    end
    check(arrRdEn == (r && !w), w ? "R8" : "R5", {35'd0, arrRdEn}, {35'd0, r && !w});
    if (r && !w) begin
      check(arrRdAddr == ra, "R5", {30'd0, arrRdAddr}, {30'd0, ra});
      expRd = 1; expData = refMem[ra];
    end else expRd = 0;
    if (w) begin
      refMem[wa] = laneMerge(refMem[wa], wd, wm);
      bValid = 1; bAddr = wa; bData = wd; bMask = wm;
    end
    @(negedge clk);
    wrReq = 0; rdReq = 0;
    check(rdValid == expRd, expRd ? "R5" : (r ? "R8" : "R4"), {35'd0, rdValid}, {35'd0, expRd});
    if (expRd) check(rdData == expData, rdTag, rdData, expData);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    for (int a = 0; a < DEPTH; a++) begin
      arrMem[a] = {a[5:0], 30'h2AB5_1C3} ^ {6'd0, a[5:0], 24'h0};
      refMem[a] = arrMem[a];
    end
    arrRdQ = '0;
    repeat (4) @(negedge clk);
    check(rdValid == 0 && arrWrEn == 0 && arrRdEn == 0, "R1", {33'd0, rdValid, arrWrEn, arrRdEn}, '0);
    rstN = 1;
    @(negedge clk);
    // R1: read before any write returns array content
    step(0, 1, 0, 0, 0, 6'd5, "R1");
    // R2: first write parks only
    step(1, 0, 6'd5, 36'hA_BCDE_F012, 4'hF, 0, "R2");
    // R6 full-mask hit, repeated reads keep the entry (R4)
    for (int k = 0; k < 4; k++) step(0, 1, 0, 0, 0, 6'd5, "R6");
    step(0, 0, 0, 0, 0, 0, "R4");
    step(0, 1, 0, 0, 0, 6'd5, "R4");
    // R7 miss
    step(0, 1, 0, 0, 0, 6'd6, "R7");
    // R3 commit, partial-mask hit R6
    step(1, 0, 6'd5, 36'h1_2345_6789, 4'b0101, 0, "R3");
    step(0, 1, 0, 0, 0, 6'd5, "R6");
    // R8 collision: write wins, read ignored
    step(1, 1, 6'd9, 36'h9_9999_9999, 4'b1010, 6'd5, "R8");
    // committed data now served from array
    step(0, 1, 0, 0, 0, 6'd5, "R7");
    step(0, 1, 0, 0, 0, 6'd9, "R6");
    // R9 random stream on a narrow address range
    for (int n = 0; n < 4000; n++) begin
      int p = $urandom_range(0, 99);
      bit w = (p < 40);
      bit r = (p >= 35 && p < 90);
      step(w, r, 6'($urandom_range(0, 7)), {$urandom, $urandom}, 4'($urandom),
           6'($urandom_range(0, 7)), "R9");
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule